// File: doc/BRIEF.md
# Reset and Stop-Recovery Sequencer

This block is the reset controller of a small microcontroller. It accepts four kinds of reset or wake events: a power-on reset, an active-low external reset pin, a reset request written by the debug logic, and, while the chip is in stop mode, either a watchdog time-out or a transition on an enabled GPIO wake pin. For each event it holds the CPU for a fixed time. The first part of that time is counted on the slow watchdog oscillator and the second part on the system clock. A one-hot cause register records which event caused the last hold.

The events fall into two classes. A full system reset pulls the chip-wide reset low for the whole hold; the power-on, pin and debug events are of this class. A stop-mode recovery only holds the CPU and rewrites the cause register, and leaves every other register alone. A watchdog time-out in interrupt mode may also raise a wake interrupt at the moment the hold ends. The debug logic stays out of every reset except power-on.

The reset pin and the wake pins pass through two-flop synchronizers. The slow-clock count is started and acknowledged through toggle signals that cross each way through two-flop synchronizers.

Top module: `rst_recovery_seq`

## Requirements
- R1: While `por_n` is low, `cpu_hold`=1, `sys_rst_n`=0, `dbg_rst_n`=0 and `status_o`=4'b0001. After `por_n` rises, a full hold sequence runs. `dbg_rst_n` goes high and stays high.
- R2: The synchronized reset pin must be seen low on 4 consecutive system-clock edges before a reset starts. A low pulse of 3 system cycles leaves `cpu_hold` at 0 and `status_o` unchanged. A pulse of 4 cycles starts a full reset.
- R3: If the synchronized pin is still low when the hold count ends, the hold lasts until the first system edge at which the synchronized pin is high.
- R4: `status_o` is one-hot. Bit 0 records power-on, bit 1 the pin, bit 2 the debug request and bit 3 a stop recovery. A new sequence sets only its own bit and clears the other three.
- R5: A debug request (`dbg_rst_req`=1 while idle) starts a full reset. It pulses `dbg_req_clr` for exactly one cycle and keeps `dbg_rst_n` high.
- R6: The hold lasts SLOW_CYCLES (66) watchdog-clock cycles plus FAST_CYCLES (16) system cycles, plus the synchronizer latency. The start toggle crosses in 2 watchdog edges and the count begins on the third. The done toggle takes 3 system edges to return. With a 200 ns watchdog clock whose rising edges fall 5 ns after system falling edges, a debug or watchdog event driven at a system falling edge just after a watchdog rising edge gives 707 sampled hold cycles. The same setup gives 705 for a GPIO event and 702 for a pin event.
- R7: During a stop recovery `sys_rst_n` stays 1 and `status_o` becomes 4'b1000.
- R8: In stop mode, two events each start a stop recovery with no interrupt: a transition on a wake pin whose enable bit is 1, and a watchdog time-out with `wdt_irq_mode`=0.
- R9: In stop mode, a watchdog time-out with `wdt_irq_mode`=1 starts a stop recovery. At release, `wake_irq` pulses for one cycle, in the same cycle that `cpu_hold` falls, only if `irq_enable` was 1 when the event was seen.
- R10: Outside stop mode, watchdog time-outs and wake-pin transitions have no effect. A transition on a wake pin whose enable bit is 0 has no effect even in stop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| wdo_clk | input | 1 | Slow watchdog oscillator clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| dbg_rst_req | input | 1 | Reset request from debug logic, held until cleared |
| stop_mode | input | 1 | CPU is in stop mode |
| wdt_timeout | input | 1 | Watchdog time-out pulse (system clock domain) |
| wdt_irq_mode | input | 1 | 1: watchdog time-out configured as interrupt |
| irq_enable | input | 1 | Global interrupt enable |
| wake_pins | input | WAKE_W | GPIO wake inputs, asynchronous |
| wake_en | input | WAKE_W | Per-pin wake enable |
| sys_rst_n | output | 1 | Chip-wide reset, active low |
| dbg_rst_n | output | 1 | Debug logic reset, active low, power-on only |
| cpu_hold | output | 1 | CPU held; vector fetch follows its fall |
| dbg_req_clr | output | 1 | One-cycle pulse that clears the debug request |
| wake_irq | output | 1 | One-cycle watchdog wake interrupt |
| status_o | output | 4 | One-hot cause of the last hold |

## Verification
The assertions assume these things about the inputs:
- `dbg_rst_req` stays high until `dbg_req_clr` is seen.
- `wdt_timeout`, `stop_mode`, `wdt_irq_mode`, `irq_enable` and `wake_en` are synchronous to the system clock and stay stable while a hold runs.

The pin-filter property also assumes that the synchronized pin is the only path to a pin reset.

The stimulus meets these assumptions in three ways:
- It drives every input on system falling edges.
- It sets the configuration before each event and waits for the hold to end before it changes anything.
- It lowers the debug request only after the clear pulse.

Each event is launched just after a watchdog rising edge, so the clock-crossing latency is fixed and the hold lengths can be predicted exactly.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_START,
    SQ_SLOW,
    SQ_FAST,
    SQ_PIN
  } seq_state_e;

  localparam int CAUSE_W   = 4;
  localparam int CAUSE_POR = 0;
  localparam int CAUSE_PIN = 1;
  localparam int CAUSE_DBG = 2;
  localparam int CAUSE_STP = 3;

  function automatic logic [CAUSE_W-1:0] cause_onehot(input int idx);
    logic [CAUSE_W-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/rrs_sync.sv
module rrs_sync #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (s == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= {WIDTH{RST_VAL}};
      else        stage_q[s] <= src;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rrs_pin_filter.sv
module rrs_pin_filter #(
  parameter int MIN_LOW = 4,
  parameter int STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_ok,
  output logic accept
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);

  logic [CW-1:0] lcnt_q, lcnt_d;

  rrs_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_n), .q(pin_ok)
  );

  assign accept = !pin_ok && (lcnt_q == LAST);

  always_comb begin
    lcnt_d = lcnt_q;
    if (pin_ok)              lcnt_d = '0;
    else if (lcnt_q != LAST) lcnt_d = lcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lcnt_q <= '0;
    else        lcnt_q <= lcnt_d;
  end
endmodule

// File: rtl/rrs_slow_timer.sv
module rrs_slow_timer #(
  parameter int CYCLES = 66,
  parameter int STAGES = 2
) (
  input  logic wclk,
  input  logic wrst_n,
  input  logic start_tgl,
  output logic done_tgl
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic          start_s, start_seen_q;
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          start_evt;

  rrs_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_start_sync (
    .clk(wclk), .rst_n(wrst_n), .d(start_tgl), .q(start_s)
  );

  assign start_evt = start_s ^ start_seen_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (start_evt) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = ~done_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      start_seen_q <= 1'b0;
      busy_q       <= 1'b0;
      cnt_q        <= '0;
      done_q       <= 1'b0;
    end else begin
      start_seen_q <= start_s;
      busy_q       <= busy_d;
      cnt_q        <= cnt_d;
      done_q       <= done_d;
    end
  end

  assign done_tgl = done_q;
endmodule

// File: rtl/rst_recovery_seq.sv
module rst_recovery_seq
  import rrs_pkg::*;
#(
  parameter int WAKE_W      = 8,
  parameter int SLOW_CYCLES = 66,
  parameter int FAST_CYCLES = 16,
  parameter int PIN_MIN_LOW = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               sys_clk,
  input  logic               wdo_clk,
  input  logic               por_n,
  input  logic               ext_rst_n,
  input  logic               dbg_rst_req,
  input  logic               stop_mode,
  input  logic               wdt_timeout,
  input  logic               wdt_irq_mode,
  input  logic               irq_enable,
  input  logic [WAKE_W-1:0]  wake_pins,
  input  logic [WAKE_W-1:0]  wake_en,
  output logic               sys_rst_n,
  output logic               dbg_rst_n,
  output logic               cpu_hold,
  output logic               dbg_req_clr,
  output logic               wake_irq,
  output logic [CAUSE_W-1:0] status_o
);
  localparam int FCW = (FAST_CYCLES > 1) ? $clog2(FAST_CYCLES) : 1;
  localparam logic [FCW-1:0] FAST_LAST = FCW'(FAST_CYCLES - 1);

  logic srst_n, wrst_n;
  logic pin_ok, pin_accept;
  logic done_s, done_tgl;
  logic [WAKE_W-1:0] wake_s;
  logic wake_hit;

  seq_state_e         state_q, state_d;
  logic [FCW-1:0]     fcnt_q, fcnt_d;
  logic               hold_q, hold_d;
  logic               rstn_q, rstn_d;
  logic [CAUSE_W-1:0] stat_q, stat_d;
  logic               irqp_q, irqp_d;
  logic               irq_q, irq_d;
  logic               clr_q, clr_d;
  logic               tgl_q, tgl_d;
  logic               dseen_q, dseen_d;
  logic [WAKE_W-1:0]  wprev_q;

  // Reset synchronizers: asynchronous assert, synchronous release per domain
  rrs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_srst (
    .clk(sys_clk), .rst_n(por_n), .d(1'b1), .q(srst_n)
  );
  rrs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wrst (
    .clk(wdo_clk), .rst_n(por_n), .d(1'b1), .q(wrst_n)
  );

  rrs_pin_filter #(.MIN_LOW(PIN_MIN_LOW), .STAGES(SYNC_STAGES)) u_pin (
    .clk(sys_clk), .rst_n(srst_n), .pin_n(ext_rst_n),
    .pin_ok(pin_ok), .accept(pin_accept)
  );

  rrs_sync #(.WIDTH(WAKE_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wake_sync (
    .clk(sys_clk), .rst_n(srst_n), .d(wake_pins), .q(wake_s)
  );

  rrs_slow_timer #(.CYCLES(SLOW_CYCLES), .STAGES(SYNC_STAGES)) u_slow (
    .wclk(wdo_clk), .wrst_n(wrst_n), .start_tgl(tgl_q), .done_tgl(done_tgl)
  );

  rrs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_done_sync (
    .clk(sys_clk), .rst_n(srst_n), .d(done_tgl), .q(done_s)
  );

  assign wake_hit = |((wake_s ^ wprev_q) & wake_en);

  always_comb begin
    state_d = state_q;
    fcnt_d  = fcnt_q;
    hold_d  = hold_q;
    rstn_d  = rstn_q;
    stat_d  = stat_q;
    irqp_d  = irqp_q;
    tgl_d   = tgl_q;
    dseen_d = dseen_q;
    irq_d   = 1'b0;
    clr_d   = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (pin_accept || dbg_rst_req) begin
          state_d = SQ_SLOW;
          tgl_d   = ~tgl_q;
          hold_d  = 1'b1;
          rstn_d  = 1'b0;
          irqp_d  = 1'b0;
          stat_d  = pin_accept ? cause_onehot(CAUSE_PIN) : cause_onehot(CAUSE_DBG);
          clr_d   = !pin_accept;
        end else if (stop_mode && (wdt_timeout || wake_hit)) begin
          state_d = SQ_SLOW;
          tgl_d   = ~tgl_q;
          hold_d  = 1'b1;
          irqp_d  = wdt_timeout && wdt_irq_mode && irq_enable;
          stat_d  = cause_onehot(CAUSE_STP);
        end
      end
      SQ_START: begin
        state_d = SQ_SLOW;
        tgl_d   = ~tgl_q;
      end
      SQ_SLOW: begin
        if (done_s != dseen_q) begin
          dseen_d = done_s;
          state_d = SQ_FAST;
          fcnt_d  = '0;
        end
      end
      SQ_FAST: begin
        if (fcnt_q != FAST_LAST) begin
          fcnt_d = fcnt_q + 1'b1;
        end else if (!pin_ok) begin
          state_d = SQ_PIN;
        end else begin
          state_d = SQ_IDLE;
          hold_d  = 1'b0;
          rstn_d  = 1'b1;
          irq_d   = irqp_q;
          irqp_d  = 1'b0;
        end
      end
      SQ_PIN: begin
        if (pin_ok) begin
          state_d = SQ_IDLE;
          hold_d  = 1'b0;
          rstn_d  = 1'b1;
          irq_d   = irqp_q;
          irqp_d  = 1'b0;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge sys_clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= SQ_START;
      fcnt_q  <= '0;
      hold_q  <= 1'b1;
      rstn_q  <= 1'b0;
      stat_q  <= cause_onehot(CAUSE_POR);
      irqp_q  <= 1'b0;
      irq_q   <= 1'b0;
      clr_q   <= 1'b0;
      tgl_q   <= 1'b0;
      dseen_q <= 1'b0;
      wprev_q <= '0;
    end else begin
      state_q <= state_d;
      fcnt_q  <= fcnt_d;
      hold_q  <= hold_d;
      rstn_q  <= rstn_d;
      stat_q  <= stat_d;
      irqp_q  <= irqp_d;
      irq_q   <= irq_d;
      clr_q   <= clr_d;
      tgl_q   <= tgl_d;
      dseen_q <= dseen_d;
      wprev_q <= wake_s;
    end
  end

  assign sys_rst_n   = rstn_q;
  assign dbg_rst_n   = srst_n;
  assign cpu_hold    = hold_q;
  assign dbg_req_clr = clr_q;
  assign wake_irq    = irq_q;
  assign status_o    = stat_q;
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker (
  input logic       sys_clk,
  input logic       por_n,
  input logic       cpu_hold,
  input logic       sys_rst_n,
  input logic       dbg_rst_n,
  input logic       dbg_req_clr,
  input logic       wake_irq,
  input logic [3:0] status_o,
  input logic       pin_ok
);
  // R4: exactly one cause bit at all times
  a_r4_one_cause: assert property (@(posedge sys_clk) disable iff (!por_n)
    $countones(status_o) == 1);

  // R5: debug logic is out of reset when its request is acknowledged
  a_r5_dbg_kept: assert property (@(posedge sys_clk) disable iff (!por_n)
    dbg_req_clr |-> dbg_rst_n);

  // R5: acknowledge is a single-cycle pulse
  a_r5_clr_pulse: assert property (@(posedge sys_clk) disable iff (!por_n)
    dbg_req_clr |=> !dbg_req_clr);

  // R9: wake interrupt only coincides with the end of a hold
  a_r9_irq_at_release: assert property (@(posedge sys_clk) disable iff (!por_n)
    wake_irq |-> $fell(cpu_hold));

  // R3: release only when the synchronized pin is high
  a_r3_release_pin_high: assert property (@(posedge sys_clk) disable iff (!por_n)
    $fell(cpu_hold) |-> $past(pin_ok));

  // R7: chip reset never active without the CPU hold
  a_r7_rst_implies_hold: assert property (@(posedge sys_clk) disable iff (!por_n)
    !sys_rst_n |-> cpu_hold);

  // R7: a stop recovery leaves the chip reset inactive
  a_r7_stop_no_rst: assert property (@(posedge sys_clk) disable iff (!por_n)
    (cpu_hold && status_o[3]) |-> sys_rst_n);

  // R2: a pin reset starts only after four low samples
  a_r2_pin_filter: assert property (@(posedge sys_clk) disable iff (!por_n)
    ($rose(cpu_hold) && status_o[1]) |->
      (!$past(pin_ok, 1) && !$past(pin_ok, 2) && !$past(pin_ok, 3) && !$past(pin_ok, 4)));
endmodule

bind rst_recovery_seq rrs_checker chk_i (
  .sys_clk(sys_clk), .por_n(por_n), .cpu_hold(cpu_hold), .sys_rst_n(sys_rst_n),
  .dbg_rst_n(dbg_rst_n), .dbg_req_clr(dbg_req_clr), .wake_irq(wake_irq),
  .status_o(status_o), .pin_ok(pin_ok)
);

// File: tb/rst_recovery_seq_tb_top.sv
module rst_recovery_seq_tb_top;
  localparam int WW = 8;
  localparam int K_PIN = 0, K_DBG = 1, K_WDT = 2, K_GPIO = 3;

  logic sys_clk = 1'b0, wdo_clk = 1'b0;
  logic por_n, ext_rst_n, dbg_rst_req, stop_mode, wdt_timeout, wdt_irq_mode, irq_enable;
  logic [WW-1:0] wake_pins, wake_en;
  logic sys_rst_n, dbg_rst_n, cpu_hold, dbg_req_clr, wake_irq;
  logic [3:0] status_o;

  int n_chk = 0, n_bad = 0;
  int exp_status = 1;

  always #10 sys_clk = ~sys_clk;
  initial begin
    #5;
    forever #100 wdo_clk = ~wdo_clk;
  end

  rst_recovery_seq #(.WAKE_W(WW)) dut_i (
    .sys_clk(sys_clk), .wdo_clk(wdo_clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
    .dbg_rst_req(dbg_rst_req), .stop_mode(stop_mode), .wdt_timeout(wdt_timeout),
    .wdt_irq_mode(wdt_irq_mode), .irq_enable(irq_enable), .wake_pins(wake_pins),
    .wake_en(wake_en), .sys_rst_n(sys_rst_n), .dbg_rst_n(dbg_rst_n),
    .cpu_hold(cpu_hold), .dbg_req_clr(dbg_req_clr), .wake_irq(wake_irq),
    .status_o(status_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_hold(input int kind, input int w);
    case (kind)
      K_PIN:   return (w - 3 > 702) ? w - 3 : 702;
      K_GPIO:  return 705;
      default: return 707;
    endcase
  endfunction

  task automatic run_evt(input int kind, input int w, input bit stp, input bit mirq,
                         input bit ien, input int bitn, input logic [WW-1:0] en);
    bit starts, full, want_irq;
    int cnt = 0, irq_n = 0, clr_n = 0, rst_low = 0, dbg_low = 0, limit;
    string treq;
    case (kind)
      K_PIN:   starts = (w >= 4);
      K_DBG:   starts = 1'b1;
      K_WDT:   starts = stp;
      default: starts = stp && en[bitn];
    endcase
    full     = (kind == K_PIN) || (kind == K_DBG);
    want_irq = starts && (kind == K_WDT) && mirq && ien;
    @(negedge sys_clk);
    stop_mode = stp; wdt_irq_mode = mirq; irq_enable = ien; wake_en = en;
    @(posedge wdo_clk);
    @(negedge sys_clk);
    limit = starts ? w + 1200 : 40;
    for (int i = 0; i < limit; i++) begin
      if (cpu_hold) cnt++;
      if (wake_irq) irq_n++;
      if (!sys_rst_n) rst_low++;
      if (!dbg_rst_n) dbg_low++;
      if (dbg_req_clr) begin clr_n++; dbg_rst_req = 1'b0; end
      if (starts && cnt > 0 && !cpu_hold && ext_rst_n) break;
      if (kind == K_PIN) ext_rst_n = (i >= w);
      if (kind == K_DBG && i == 0) dbg_rst_req = 1'b1;
      if (kind == K_WDT) wdt_timeout = (i == 0);
      if (kind == K_GPIO && i == 0) wake_pins[bitn] = ~wake_pins[bitn];
      @(negedge sys_clk);
    end
    if (kind == K_PIN) treq = (w >= 100) ? "R3" : "R2";
    else if (!starts) treq = "R10";
    else treq = "R6";
    chk(cnt == (starts ? exp_hold(kind, w) : 0), treq, "hold cycles",
        cnt, starts ? exp_hold(kind, w) : 0);
    if (starts) exp_status = full ? ((kind == K_PIN) ? 2 : 4) : 8;
    chk(int'(status_o) == exp_status, "R4", "cause register", int'(status_o), exp_status);
    if (full) chk(rst_low == cnt, "R5", "chip reset low for whole hold", rst_low, cnt);
    else      chk(rst_low == 0, "R7", "chip reset untouched", rst_low, 0);
    chk(irq_n == (want_irq ? 1 : 0), (kind == K_WDT) ? "R9" : "R8", "wake irq pulses",
        irq_n, want_irq ? 1 : 0);
    chk(dbg_low == 0, "R5", "debug reset stays high", dbg_low, 0);
    if (kind == K_DBG) chk(clr_n == 1, "R5", "request clear pulses", clr_n, 1);
    stop_mode = 1'b0; wdt_timeout = 1'b0;
    repeat (5) @(negedge sys_clk);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int waited;
    void'($urandom(32'h5eed_0042));
    por_n = 1'b0; ext_rst_n = 1'b1; dbg_rst_req = 1'b0; stop_mode = 1'b0;
    wdt_timeout = 1'b0; wdt_irq_mode = 1'b0; irq_enable = 1'b0;
    wake_pins = '0; wake_en = '0;
    repeat (3) @(negedge sys_clk);
    // R1: state while power-on reset is applied
    chk(cpu_hold == 1'b1, "R1", "hold during por", cpu_hold, 1);
    chk(sys_rst_n == 1'b0, "R1", "chip reset during por", sys_rst_n, 0);
    chk(dbg_rst_n == 1'b0, "R1", "debug reset during por", dbg_rst_n, 0);
    chk(status_o == 4'b0001, "R1", "cause during por", int'(status_o), 1);
    por_n = 1'b1;
    waited = 0;
    while (cpu_hold && waited < 2000) begin @(negedge sys_clk); waited++; end
    chk(!cpu_hold && waited > 676, "R1", "por hold length above minimum", waited, 677);
    chk(sys_rst_n && dbg_rst_n, "R1", "resets released", int'({sys_rst_n, dbg_rst_n}), 3);
    chk(status_o == 4'b0001, "R4", "cause after por", int'(status_o), 1);
    exp_status = 1;

    // Directed corner cases
    run_evt(K_PIN, 3, 0, 0, 0, 0, '0);          // R2 reject
    run_evt(K_PIN, 4, 0, 0, 0, 0, '0);          // R2 accept
    run_evt(K_PIN, 800, 0, 0, 0, 0, '0);        // R3 extension
    run_evt(K_DBG, 0, 0, 0, 0, 0, '0);          // R5
    run_evt(K_WDT, 0, 1, 0, 1, 0, '0);          // R8 reset mode
    run_evt(K_WDT, 0, 1, 1, 1, 0, '0);          // R9 irq enabled
    run_evt(K_WDT, 0, 1, 1, 0, 0, '0);          // R9 irq disabled
    run_evt(K_GPIO, 0, 1, 0, 0, 3, 8'h08);      // R8 enabled pin
    run_evt(K_GPIO, 0, 1, 0, 0, 2, 8'hFB);      // R10 disabled pin
    run_evt(K_WDT, 0, 0, 1, 1, 0, '0);          // R10 not in stop
    run_evt(K_GPIO, 0, 0, 0, 0, 5, 8'hFF);      // R10 not in stop

    // Constrained random mix
    for (int n = 0; n < 14; n++) begin
      int kind, w, bitn;
      bit stp;
      kind = int'($urandom % 4);
      w    = 1 + int'($urandom % 6);
      stp  = (($urandom % 4) != 0);
      bitn = int'($urandom % WW);
      run_evt(kind, w, stp, 1'($urandom), 1'($urandom), bitn, WW'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule